// File: doc/BRIEF.md
# Accumulator Store Rounding Path

This block converts a 40-bit signed accumulator into a 16-bit 1.15 fractional word ready to be written to data memory. The word is the accumulator's high word (bits 31..16). It is either truncated or rounded. Rounding uses one of two rules: biased, where the word moves up whenever the discarded half-word is at least one half, or convergent, where an exact tie rounds toward an even result. After rounding, an optional write saturation step clamps any result that does not fit in the 1.15 range.

A store is presented for one cycle on `st_valid`, along with the accumulator and the control bits. A write-back store always rounds. A plain store rounds only when `st_round` is set. The block also computes the next value of the destination pointer, which advances by one word (2 bytes) in post-increment mode. The rounding and saturation logic is combinational. With `OUT_REG` = 1, which is the default, the result and the pointer are registered and appear one cycle after the request.

Top module: `acc_store_round`

## Requirements
- R1: With `st_round`=0, `st_writeback`=0 and `wsat_en`=0, `wr_data` equals accumulator bits 31..16, and bits 15..0 have no effect.
- R2: In biased mode (`rnd_conv`=0) with rounding active, the high word is incremented exactly when accumulator bit 15 is 1, that is, when the low word lies in 0x8000..0xFFFF.
- R3: In convergent mode (`rnd_conv`=1) with rounding active, a low word of exactly 0x8000 increments the high word only when accumulator bit 16 is 1. Every other low word is handled as in R2.
- R4: With `st_writeback`=1, rounding is applied even when `st_round`=0.
- R5: With `wsat_en`=1, a rounded value whose bits 40..31 (including the carry out of bit 39) are not all equal is output as 0x7FFF if it is positive and 0x8000 if it is negative. A value inside the range is output unchanged.
- R6: With `wsat_en`=0, `wr_data` is bits 31..16 of the rounded value. A carry out of rounding wraps, so for example 0x007FFF8000 rounded gives 0x8000.
- R7: `ptr_next` equals `ptr_in`+2 (modulo 2^16) when `ptr_postinc`=1, and `ptr_in` otherwise. It is captured together with the data word.
- R8: After reset, `wr_valid`, `wr_data` and `ptr_next` are 0. `wr_valid` is high in exactly the cycle after an `st_valid` cycle. While `st_valid` is low, `wr_data` and `ptr_next` hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request strobe |
| st_writeback | input | 1 | Write-back store, which forces rounding |
| st_round | input | 1 | Rounding requested by a plain store |
| rnd_conv | input | 1 | 0 = biased rounding, 1 = convergent rounding |
| wsat_en | input | 1 | Enable data write saturation |
| ptr_postinc | input | 1 | Destination pointer post-increment mode |
| ptr_in | input | 16 | Current destination pointer |
| acc_in | input | 40 | Accumulator value |
| wr_valid | output | 1 | Result valid strobe |
| wr_data | output | 16 | 1.15 word to store |
| ptr_next | output | 16 | Updated destination pointer |

## Verification
Some properties hold on every cycle, and the in-RTL assertions check them:
- the valid strobe follows the request by one cycle;
- the outputs hold while there is no request;
- the pointer steps by two in post-increment mode;
- truncation passes the high word through unchanged;
- an unsaturated rounded word never differs from the high word by more than one;
- the convergent tie with an even bit 16 stays put;
- a deeply negative accumulator clamps to 0x8000.

Other behaviours depend on specific values, so only the bench's directed scenarios can show them. These include the exact boundary 0x7FFF/0x8000 of the low word in both modes, the odd-tie increment, write-back forcing a round, the positive clamp after a rounding carry, the wrap of that same carry with saturation off, and the pointer wrap at 0xFFFE.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
  typedef enum logic {
    RND_BIASED     = 1'b0,
    RND_CONVERGENT = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/acc_round_unit.sv
module acc_round_unit
  import acc_store_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16,
  localparam int EXT_W = ACC_W - WORD_W + 1
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             round_on,
  input  rnd_mode_e        mode,
  output logic [EXT_W-1:0] upper_rnd
);
  localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] low_w;
  logic              tie;
  logic              bump;
  logic [EXT_W-1:0]  upper_ext;

  always_comb begin
    low_w     = acc[WORD_W-1:0];
    tie       = (low_w == HALF);
    upper_ext = {acc[ACC_W-1], acc[ACC_W-1:WORD_W]};
    bump      = 1'b0;
    if (round_on) begin
      if (mode == RND_CONVERGENT && tie)
        bump = acc[WORD_W];
      else
        bump = low_w[WORD_W-1];
    end
    upper_rnd = upper_ext + {{(EXT_W-1){1'b0}}, bump};
  end
endmodule

// File: rtl/acc_write_sat.sv
module acc_write_sat #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16,
  localparam int EXT_W = ACC_W - WORD_W + 1,
  localparam int HI_W  = EXT_W - WORD_W + 1
) (
  input  logic [EXT_W-1:0]  val,
  input  logic              sat_on,
  output logic [WORD_W-1:0] word
);
  logic [HI_W-1:0] hi_bits;
  logic            in_range;

  always_comb begin
    hi_bits  = val[EXT_W-1:WORD_W-1];
    in_range = (&hi_bits) | ~(|hi_bits);
    if (sat_on && !in_range)
      word = val[EXT_W-1] ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
    else
      word = val[WORD_W-1:0];
  end
endmodule

// File: rtl/acc_ptr_step.sv
module acc_ptr_step #(
  parameter int PTR_W = 16,
  parameter int STEP  = 2
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             postinc,
  output logic [PTR_W-1:0] ptr_upd
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

  always_comb ptr_upd = postinc ? (ptr + STEP_V) : ptr;
endmodule

// File: rtl/acc_store_round.sv
module acc_store_round
  import acc_store_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int WORD_W  = 16,
  parameter int PTR_W   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic              st_writeback,
  input  logic              st_round,
  input  logic              rnd_conv,
  input  logic              wsat_en,
  input  logic              ptr_postinc,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic [ACC_W-1:0]  acc_in,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr_next
);
  localparam int EXT_W = ACC_W - WORD_W + 1;

  logic [EXT_W-1:0]  upper_rnd;
  logic [WORD_W-1:0] word_c;
  logic [PTR_W-1:0]  ptr_c;
  logic              round_on;
  rnd_mode_e         mode;

  always_comb begin
    round_on = st_round | st_writeback;
    mode     = rnd_conv ? RND_CONVERGENT : RND_BIASED;
  end

  acc_round_unit #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_round (
    .acc(acc_in), .round_on(round_on), .mode(mode), .upper_rnd(upper_rnd)
  );

  acc_write_sat #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_sat (
    .val(upper_rnd), .sat_on(wsat_en), .word(word_c)
  );

  acc_ptr_step #(.PTR_W(PTR_W), .STEP(2)) u_ptr (
    .ptr(ptr_in), .postinc(ptr_postinc), .ptr_upd(ptr_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic              vld_q, vld_d;
      logic [WORD_W-1:0] data_q, data_d;
      logic [PTR_W-1:0]  ptr_q, ptr_d;
      logic              cap_en;

      always_comb begin
        cap_en = st_valid;
        vld_d  = st_valid;
        data_d = cap_en ? word_c : data_q;
        ptr_d  = cap_en ? ptr_c  : ptr_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          data_q <= '0;
          ptr_q  <= '0;
        end else begin
          vld_q  <= vld_d;
          data_q <= data_d;
          ptr_q  <= ptr_d;
        end
      end

      always_comb begin
        wr_valid = vld_q;
        wr_data  = data_q;
        ptr_next = ptr_q;
      end

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> wr_valid); // R8
      AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !wr_valid); // R8
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> ($stable(wr_data) && $stable(ptr_next))); // R8
      AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && ptr_postinc) |=> (ptr_next == $past(ptr_in) + PTR_W'(2))); // R7
      AST_TRUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_round && !st_writeback && !wsat_en)
        |=> (wr_data == $past(acc_in[2*WORD_W-1:WORD_W]))); // R1
      AST_ROUND_STEP_MAX1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !wsat_en)
        |=> ((wr_data - $past(acc_in[2*WORD_W-1:WORD_W])) <= WORD_W'(1))); // R2
      AST_CONV_EVEN_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && rnd_conv && !wsat_en && !acc_in[WORD_W]
         && acc_in[WORD_W-1:0] == {1'b1, {(WORD_W-1){1'b0}}})
        |=> (wr_data == $past(acc_in[2*WORD_W-1:WORD_W]))); // R3
      AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && wsat_en && acc_in[ACC_W-1:ACC_W-2] == 2'b10)
        |=> (wr_data == {1'b1, {(WORD_W-1){1'b0}}})); // R5
    end else begin : g_comb
      always_comb begin
        wr_valid = st_valid;
        wr_data  = word_c;
        ptr_next = ptr_c;
      end
    end
  endgenerate
endmodule

// File: tb/acc_store_round_test.sv
module acc_store_round_test;
  logic        clk;
  logic        rst_n;
  logic        st_valid, st_writeback, st_round, rnd_conv, wsat_en, ptr_postinc;
  logic [15:0] ptr_in;
  logic [39:0] acc_in;
  logic        wr_valid;
  logic [15:0] wr_data;
  logic [15:0] ptr_next;

  int n_checks;
  int n_fails;

  acc_store_round uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_writeback(st_writeback),
    .st_round(st_round), .rnd_conv(rnd_conv), .wsat_en(wsat_en),
    .ptr_postinc(ptr_postinc), .ptr_in(ptr_in), .acc_in(acc_in),
    .wr_valid(wr_valid), .wr_data(wr_data), .ptr_next(ptr_next)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one store at a falling edge; the result is registered at the next
  // rising edge and sampled at the falling edge after that.
  task automatic store(input logic [39:0] acc, input logic rnd, input logic wb,
                       input logic conv, input logic sat, input logic pinc,
                       input logic [15:0] ptr);
    @(negedge clk);
    st_valid = 1'b1; acc_in = acc; st_round = rnd; st_writeback = wb;
    rnd_conv = conv; wsat_en = sat; ptr_postinc = pinc; ptr_in = ptr;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 reset valid", {39'd0, wr_valid}, 40'd0);
    check("R8 reset data", {24'd0, wr_data}, 40'd0);
    check("R8 reset ptr", {24'd0, ptr_next}, 40'd0);
  endtask

  task automatic t_trunc();
    store(40'h00_1234_FFFF, 0, 0, 0, 0, 0, 16'h0);
    check("R1 truncate 1234FFFF", {24'd0, wr_data}, 40'h1234);
    store(40'hFF_ABCD_8000, 0, 0, 1, 0, 0, 16'h0);
    check("R1 truncate negative", {24'd0, wr_data}, 40'hABCD);
  endtask

  task automatic t_biased();
    store(40'h00_1234_8000, 1, 0, 0, 0, 0, 16'h0);
    check("R2 biased 0x8000 up", {24'd0, wr_data}, 40'h1235);
    store(40'h00_1234_7FFF, 1, 0, 0, 0, 0, 16'h0);
    check("R2 biased 0x7FFF stays", {24'd0, wr_data}, 40'h1234);
    store(40'h00_1234_FFFF, 1, 0, 0, 0, 0, 16'h0);
    check("R2 biased 0xFFFF up", {24'd0, wr_data}, 40'h1235);
  endtask

  task automatic t_convergent();
    store(40'h00_1234_8000, 1, 0, 1, 0, 0, 16'h0);
    check("R3 conv even tie", {24'd0, wr_data}, 40'h1234);
    store(40'h00_1235_8000, 1, 0, 1, 0, 0, 16'h0);
    check("R3 conv odd tie", {24'd0, wr_data}, 40'h1236);
    store(40'h00_1234_8001, 1, 0, 1, 0, 0, 16'h0);
    check("R3 conv above tie", {24'd0, wr_data}, 40'h1235);
    store(40'h00_1235_7FFF, 1, 0, 1, 0, 0, 16'h0);
    check("R3 conv below tie", {24'd0, wr_data}, 40'h1235);
  endtask

  task automatic t_writeback();
    store(40'h00_1234_C000, 0, 1, 0, 0, 0, 16'h0);
    check("R4 writeback forces round", {24'd0, wr_data}, 40'h1235);
    store(40'h00_1235_8000, 0, 1, 1, 0, 0, 16'h0);
    check("R4 writeback convergent", {24'd0, wr_data}, 40'h1236);
  endtask

  task automatic t_saturate();
    store(40'h01_0000_0000, 0, 0, 0, 1, 0, 16'h0);
    check("R5 positive clamp", {24'd0, wr_data}, 40'h7FFF);
    store(40'hFE_0000_0000, 0, 0, 0, 1, 0, 16'h0);
    check("R5 negative clamp", {24'd0, wr_data}, 40'h8000);
    store(40'h00_4000_0000, 0, 0, 0, 1, 0, 16'h0);
    check("R5 in range untouched", {24'd0, wr_data}, 40'h4000);
    store(40'h00_7FFF_8000, 1, 0, 0, 1, 0, 16'h0);
    check("R5 clamp after round carry", {24'd0, wr_data}, 40'h7FFF);
    store(40'hFF_8000_0000, 0, 0, 0, 1, 0, 16'h0);
    check("R5 most negative in range", {24'd0, wr_data}, 40'h8000);
  endtask

  task automatic t_nosat();
    store(40'h00_7FFF_8000, 1, 0, 0, 0, 0, 16'h0);
    check("R6 carry wraps", {24'd0, wr_data}, 40'h8000);
    store(40'h01_2345_0000, 0, 0, 0, 0, 0, 16'h0);
    check("R6 out of range no clamp", {24'd0, wr_data}, 40'h2345);
  endtask

  task automatic t_pointer();
    store(40'h0, 0, 1, 0, 0, 1, 16'h0100);
    check("R7 post-increment", {24'd0, ptr_next}, 40'h0102);
    store(40'h0, 0, 1, 0, 0, 0, 16'h0100);
    check("R7 no increment", {24'd0, ptr_next}, 40'h0100);
    store(40'h0, 0, 1, 0, 0, 1, 16'hFFFE);
    check("R7 pointer wrap", {24'd0, ptr_next}, 40'h0000);
  endtask

  task automatic t_timing();
    @(negedge clk);
    st_valid = 1'b1; acc_in = 40'h00_5555_0000; st_round = 0; st_writeback = 0;
    rnd_conv = 0; wsat_en = 0; ptr_postinc = 1; ptr_in = 16'h0200;
    check("R8 no valid before edge", {39'd0, wr_valid}, 40'd0);
    @(negedge clk);
    st_valid = 1'b0;
    check("R8 valid one cycle later", {39'd0, wr_valid}, 40'd1);
    acc_in = 40'h00_AAAA_FFFF; st_round = 1; ptr_in = 16'h0300;
    @(negedge clk);
    check("R8 valid drops", {39'd0, wr_valid}, 40'd0);
    check("R8 data held", {24'd0, wr_data}, 40'h5555);
    check("R8 ptr held", {24'd0, ptr_next}, 40'h0202);
  endtask

  initial begin
    n_checks = 0; n_fails = 0;
    rst_n = 1'b0; st_valid = 0; st_writeback = 0; st_round = 0; rnd_conv = 0;
    wsat_en = 0; ptr_postinc = 0; ptr_in = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_trunc();
    t_biased();
    t_convergent();
    t_writeback();
    t_saturate();
    t_nosat();
    t_pointer();
    t_timing();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule